// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table kept in main memory. A requester hands it a virtual address and the current directory base register value. The walker fetches one directory entry and then one page table entry with word reads over a valid/ready request channel and a valid-only response channel. It returns the physical address together with the leaf entry's control bits, or a fault flag when either entry is marked not present.

Pages are 4096 bytes. The top ten address bits select a directory entry, the next ten select a page table entry, and the low twelve bits are the page offset. Each entry is a 32-bit word whose upper 20 bits hold a page frame base. Its low bits are flags. One walk is in flight at a time, and the result stays on the response port until the requester takes it. A TLB in front of this block would store the returned control bits next to the translation.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1, and `mem_req_valid_o` and `rsp_valid_o` are 0.
- R2: The first memory read of a walk uses address {directory base bits 31:12, virtual address bits 31:22, 2'b00}.
- R3: When the directory entry has bit 0 (present) set, the second read uses address {directory entry bits 31:12, virtual address bits 21:12, 2'b00}.
- R4: When both entries are present, `rsp_paddr_o` is {page table entry bits 31:12, virtual address bits 11:0}. `rsp_ctrl_o` is the page table entry's bits 11:0, where bit 0 is present, bit 1 dirty and bit 2 read-only. `rsp_fault_o` is 0.
- R5: A directory entry with bit 0 clear ends the walk with `rsp_fault_o` = 1, and no second memory read is issued.
- R6: A page table entry with bit 0 clear ends the walk with `rsp_fault_o` = 1. On any fault `rsp_paddr_o` and `rsp_ctrl_o` are 0.
- R7: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request stays valid and its address does not change.
- R8: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the response and its fields stay unchanged. Once the response is accepted, `rsp_valid_o` drops and the walker is idle again.
- R9: `req_ready_o` is 0 from the cycle after a request is taken until its result is accepted. Request inputs in that time do not affect the walk.
- R10: A `mem_rsp_valid_i` pulse while no read is outstanding is ignored. It produces no response and does not disturb the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker can take a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_dirbase_i | input | 32 | Directory base register value |
| mem_req_valid_o | output | 1 | Memory word read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 32 | Byte address of the word to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data word |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Requester accepts the result |
| rsp_paddr_o | output | 32 | Physical address, 0 on fault |
| rsp_fault_o | output | 1 | Entry not present at either level |
| rsp_ctrl_o | output | 12 | Page table entry control bits, 0 on fault |

## Verification
The bench builds the walker with its default widths: a 32-bit address and a 12-bit offset, which give 10-bit indices at each level and 20-bit frame bases. At those values every index bit and every base bit can be driven to both 0 and 1 by random addresses and entries. Directed cases cover the all-zero and all-ones virtual address, a missing entry at each level and set dirty and read-only flags. Random stalls on the memory request, the memory response and the result accept test the hold rules at every handshake point.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_READ_DIR = 3'd1,
    ST_WAIT_DIR = 3'd2,
    ST_READ_PTE = 3'd3,
    ST_WAIT_PTE = 3'd4,
    ST_DONE     = 3'd5
  } walk_state_e;

  localparam int unsigned PRESENT_BIT = 0;
  localparam int unsigned DIRTY_BIT   = 1;
  localparam int unsigned RDONLY_BIT  = 2;

endpackage

// File: rtl/pw_fsm.sv
module pw_fsm
  import pw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  output logic req_ready_o,
  output logic mem_req_valid_o,
  input  logic mem_req_ready_i,
  input  logic mem_rsp_valid_i,
  input  logic mem_rsp_present_i,
  output logic rsp_valid_o,
  input  logic rsp_ready_i,
  output logic ld_req_o,
  output logic ld_dir_o,
  output logic dir_miss_o,
  output logic ld_pte_o,
  output logic sel_pte_o
);

  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid_i) state_d = ST_READ_DIR;
      ST_READ_DIR: if (mem_req_ready_i) state_d = ST_WAIT_DIR;
      ST_WAIT_DIR: if (mem_rsp_valid_i)
                     state_d = mem_rsp_present_i ? ST_READ_PTE : ST_DONE;
      ST_READ_PTE: if (mem_req_ready_i) state_d = ST_WAIT_PTE;
      ST_WAIT_PTE: if (mem_rsp_valid_i) state_d = ST_DONE;
      ST_DONE:     if (rsp_ready_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_READ_DIR) || (state_q == ST_READ_PTE);
  assign sel_pte_o       = (state_q == ST_READ_PTE);
  assign rsp_valid_o     = (state_q == ST_DONE);
  assign ld_req_o        = req_ready_o && req_valid_i;
  assign ld_dir_o        = (state_q == ST_WAIT_DIR) && mem_rsp_valid_i && mem_rsp_present_i;
  assign dir_miss_o      = (state_q == ST_WAIT_DIR) && mem_rsp_valid_i && !mem_rsp_present_i;
  assign ld_pte_o        = (state_q == ST_WAIT_PTE) && mem_rsp_valid_i;

  assert_dir_miss_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_miss_o |=> rsp_valid_o && !mem_req_valid_o);

  assert_one_walk_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || rsp_valid_o) |-> !req_ready_o);

  assert_stray_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_valid_i && mem_rsp_valid_i) |=> req_ready_o && !rsp_valid_o);

endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_req_i,
  input  logic              ld_dir_i,
  input  logic              sel_pte_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [ADDR_W-1:0] dirbase_i,
  input  logic [ADDR_W-1:0] dir_entry_i,
  output logic [ADDR_W-1:0] vaddr_o,
  output logic [ADDR_W-1:0] mem_addr_o
);

  localparam int unsigned BASE_W = ADDR_W - OFF_W;
  localparam int unsigned IDX_W  = OFF_W - 2;
  localparam int unsigned LO_IDX = OFF_W;
  localparam int unsigned HI_IDX = OFF_W + IDX_W;

  logic [ADDR_W-1:0] vaddr_q;
  logic [BASE_W-1:0] dir_base_q;
  logic [BASE_W-1:0] pt_base_q;
  logic [ADDR_W-1:0] dir_addr, pte_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q    <= '0;
      dir_base_q <= '0;
      pt_base_q  <= '0;
    end else begin
      if (ld_req_i) begin
        vaddr_q    <= vaddr_i;
        dir_base_q <= dirbase_i[ADDR_W-1:OFF_W];
      end
      if (ld_dir_i) pt_base_q <= dir_entry_i[ADDR_W-1:OFF_W];
    end
  end

  // entries are 4 bytes: index lands on bits OFF_W-1:2
  assign dir_addr = {dir_base_q, vaddr_q[HI_IDX +: IDX_W], 2'b00};
  assign pte_addr = {pt_base_q,  vaddr_q[LO_IDX +: IDX_W], 2'b00};

  assign mem_addr_o = sel_pte_i ? pte_addr : dir_addr;
  assign vaddr_o    = vaddr_q;

endmodule

// File: rtl/pw_result.sv
module pw_result
  import pw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_miss_i,
  input  logic              ld_pte_i,
  input  logic [ADDR_W-1:0] pte_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_ready_i,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              fault_o,
  output logic [OFF_W-1:0]  ctrl_o
);

  logic pte_present;
  assign pte_present = pte_i[PRESENT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_o <= '0;
      fault_o <= 1'b0;
      ctrl_o  <= '0;
    end else if (dir_miss_i) begin
      paddr_o <= '0;
      fault_o <= 1'b1;
      ctrl_o  <= '0;
    end else if (ld_pte_i) begin
      if (pte_present) begin
        paddr_o <= {pte_i[ADDR_W-1:OFF_W], vaddr_i[OFF_W-1:0]};
        fault_o <= 1'b0;
        ctrl_o  <= pte_i[OFF_W-1:0];
      end else begin
        paddr_o <= '0;
        fault_o <= 1'b1;
        ctrl_o  <= '0;
      end
    end
  end

  assert_rsp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && !rsp_ready_i) |=>
      rsp_valid_i && $stable(paddr_o) && $stable(fault_o) && $stable(ctrl_o));

  assert_fault_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && fault_o) |-> (paddr_o == '0) && (ctrl_o == '0));

  assert_ok_present_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && !fault_o) |-> ctrl_o[PRESENT_BIT]);

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic [ADDR_W-1:0] req_dirbase_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic              rsp_fault_o,
  output logic [OFF_W-1:0]  rsp_ctrl_o
);

  logic ld_req, ld_dir, dir_miss, ld_pte, sel_pte;
  logic [ADDR_W-1:0] vaddr_q;

  pw_fsm u_fsm (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .req_valid_i       (req_valid_i),
    .req_ready_o       (req_ready_o),
    .mem_req_valid_o   (mem_req_valid_o),
    .mem_req_ready_i   (mem_req_ready_i),
    .mem_rsp_valid_i   (mem_rsp_valid_i),
    .mem_rsp_present_i (mem_rsp_data_i[pw_pkg::PRESENT_BIT]),
    .rsp_valid_o       (rsp_valid_o),
    .rsp_ready_i       (rsp_ready_i),
    .ld_req_o          (ld_req),
    .ld_dir_o          (ld_dir),
    .dir_miss_o        (dir_miss),
    .ld_pte_o          (ld_pte),
    .sel_pte_o         (sel_pte)
  );

  pw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_req_i    (ld_req),
    .ld_dir_i    (ld_dir),
    .sel_pte_i   (sel_pte),
    .vaddr_i     (req_vaddr_i),
    .dirbase_i   (req_dirbase_i),
    .dir_entry_i (mem_rsp_data_i),
    .vaddr_o     (vaddr_q),
    .mem_addr_o  (mem_req_addr_o)
  );

  pw_result #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_miss_i  (dir_miss),
    .ld_pte_i    (ld_pte),
    .pte_i       (mem_rsp_data_i),
    .vaddr_i     (vaddr_q),
    .rsp_valid_i (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i),
    .paddr_o     (rsp_paddr_o),
    .fault_o     (rsp_fault_o),
    .ctrl_o      (rsp_ctrl_o)
  );

  assert_mem_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> mem_req_valid_o && $stable(mem_req_addr_o));

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> req_ready_o && !mem_req_valid_o && !rsp_valid_o);

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [31:0] req_dirbase_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [31:0] rsp_paddr_o;
  logic        rsp_fault_o;
  logic [11:0] rsp_ctrl_o;

  int checks = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  pt_walker u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_vaddr_i, .req_dirbase_i,
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_addr_o, .mem_rsp_valid_i,
    .mem_rsp_data_i, .rsp_valid_o, .rsp_ready_i, .rsp_paddr_o, .rsp_fault_o,
    .rsp_ctrl_o
  );

  function automatic logic [31:0] dir_addr(input logic [31:0] va, input logic [31:0] db);
    return {db[31:12], va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] pte_addr(input logic [31:0] va, input logic [31:0] de);
    return {de[31:12], va[21:12], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data,
                       input string tag);
    int n = 0;
    logic [31:0] a0;
    while (!mem_req_valid_o && n < 50) begin @(negedge clk_i); n++; end
    chk(mem_req_valid_o === 1'b1, {tag, " read issued"}, 32'(mem_req_valid_o), 1);
    a0 = mem_req_addr_o;
    repeat ($urandom % 3) begin
      @(negedge clk_i);
      chk(mem_req_valid_o === 1'b1 && mem_req_addr_o === a0, "R7 request held",
          mem_req_addr_o, a0);
    end
    chk(mem_req_addr_o === exp_addr, {tag, " read address"}, mem_req_addr_o, exp_addr);
    mem_req_ready_i = 1'b1;
    @(negedge clk_i);
    mem_req_ready_i = 1'b0;
    repeat ($urandom % 3) @(negedge clk_i);
    mem_rsp_valid_i = 1'b1;
    mem_rsp_data_i  = data;
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i  = $urandom;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] db,
                      input logic [31:0] de, input logic [31:0] pe, input bit junk);
    logic        exp_f;
    logic [31:0] exp_pa;
    logic [11:0] exp_c;
    logic [31:0] pa0;
    int n = 0;
    exp_f  = !de[0] || !pe[0];
    exp_pa = exp_f ? 32'h0 : {pe[31:12], va[11:0]};
    exp_c  = exp_f ? 12'h0 : pe[11:0];
    chk(req_ready_o === 1'b1, "R9 ready when idle", 32'(req_ready_o), 1);
    req_valid_i   = 1'b1;
    req_vaddr_i   = va;
    req_dirbase_i = db;
    @(negedge clk_i);
    if (junk) begin
      req_vaddr_i   = ~va;
      req_dirbase_i = ~db;
    end else req_valid_i = 1'b0;
    chk(req_ready_o === 1'b0, "R9 busy after take", 32'(req_ready_o), 0);
    serve(dir_addr(va, db), de, "R2");
    if (de[0]) serve(pte_addr(va, de), pe, "R3");
    else chk(mem_req_valid_o === 1'b0 && rsp_valid_o === 1'b1,
             "R5 no second read", 32'(mem_req_valid_o), 0);
    while (!rsp_valid_o && n < 50) begin @(negedge clk_i); n++; end
    req_valid_i = 1'b0;
    chk(rsp_valid_o === 1'b1, "R4 result valid", 32'(rsp_valid_o), 1);
    chk(rsp_fault_o === exp_f, exp_f ? (de[0] ? "R6 leaf fault" : "R5 dir fault")
                                     : "R4 no fault", 32'(rsp_fault_o), 32'(exp_f));
    chk(rsp_paddr_o === exp_pa, exp_f ? "R6 paddr zero" : "R4 paddr",
        rsp_paddr_o, exp_pa);
    chk(rsp_ctrl_o === exp_c, exp_f ? "R6 ctrl zero" : "R4 ctrl bits",
        32'(rsp_ctrl_o), 32'(exp_c));
    pa0 = rsp_paddr_o;
    repeat ($urandom % 4) begin
      @(negedge clk_i);
      chk(rsp_valid_o === 1'b1 && rsp_paddr_o === pa0 && rsp_fault_o === exp_f,
          "R8 result held", rsp_paddr_o, pa0);
    end
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    chk(rsp_valid_o === 1'b0 && req_ready_o === 1'b1, "R8 released after accept",
        32'({rsp_valid_o, req_ready_o}), 32'h1);
  endtask

  initial begin
    while (1) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        bad++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] va, db, de, pe;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk(req_ready_o === 1'b1 && mem_req_valid_o === 1'b0 && rsp_valid_o === 1'b0,
        "R1 reset state", 32'({req_ready_o, mem_req_valid_o, rsp_valid_o}), 32'h4);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o === 1'b1 && mem_req_valid_o === 1'b0 && rsp_valid_o === 1'b0,
        "R1 idle after reset", 32'({req_ready_o, mem_req_valid_o, rsp_valid_o}), 32'h4);

    // directed corners
    walk(32'h0000_0000, 32'h0000_0000, 32'h0000_1001, 32'h0000_2001, 1'b0);
    walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_F001, 32'hFFFF_F007, 1'b0);
    walk(32'h0000_0F74, 32'h1234_5000, 32'hABCD_E003, 32'h0000_2003, 1'b0);
    walk(32'h8040_1ABC, 32'h0010_0000, 32'h0020_0000, 32'h5555_5001, 1'b0); // R5
    walk(32'h0123_4567, 32'h0300_0000, 32'h0400_0001, 32'h7777_7006, 1'b0); // R6
    walk(32'hDEAD_BEEF, 32'hCAFE_0000, 32'h0BAD_0001, 32'hF00D_0005, 1'b1); // R9

    // R10: stray memory response while idle
    mem_rsp_valid_i = 1'b1;
    mem_rsp_data_i  = 32'hFFFF_FFFF;
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    @(negedge clk_i);
    chk(rsp_valid_o === 1'b0 && req_ready_o === 1'b1 && mem_req_valid_o === 1'b0,
        "R10 stray response ignored", 32'({rsp_valid_o, req_ready_o}), 32'h1);
    walk(32'h3C00_5A5A, 32'h0000_8000, 32'h1111_1001, 32'h2222_2003, 1'b0); // R10

    for (int i = 0; i < 300; i++) begin
      va = $urandom;
      db = $urandom;
      de = $urandom;
      pe = $urandom;
      de[0] = ($urandom % 8) != 0;
      pe[0] = ($urandom % 8) != 0;
      walk(va, db, de, pe, ($urandom % 4) == 0);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule